// File: doc/BRIEF.md
# Row-to-Column Transpose Buffer with Paired Registers

This block sits between the row pass and the column pass of a two-dimensional 8x8 transform. Results from the row pass arrive one element per clock in row-major order. The block writes each element into a bank of input registers. Once the sixty-fourth element of a block has been written, the whole bank is copied in one clock into a second, paired bank. The paired bank is then read out one element per clock in column-major order, feeding the column pass.

Each matrix position has two registers, so the next block can be written while the current block is being read. With a steady input stream the output is a steady stream as well, and neither side ever stalls. When the input stalls, the write position simply waits. A start marker on the input realigns the write position to the first element of a block. A matching marker on the output flags the first element of each transposed block.

Top module: `xpose_dbl_buf`

## Requirements
- R1: After reset, `out_valid` and `out_first` are 0. `out_valid` stays 0 until a full block of 64 elements has been written.
- R2: With uninterrupted input, the first output element of a block is presented after the 65th rising edge that follows the edge on which that block's first element was written. The copy takes place on the edge after the 64th write, and the output register is loaded on the edge after that.
- R3: Input element number i (i = 8*row + col, counted in arrival order) leaves the block as output number k = 8*col + row. Output k of a block therefore carries the input element with index 8*(k mod 8) + (k div 8).
- R4: Each block is emitted as 64 outputs on 64 consecutive cycles with `out_valid` high. `out_first` is 1 on the first of these outputs only, and `out_first` is never 1 while `out_valid` is 0.
- R5: Blocks written back to back with no gap come out back to back with no gap: 128 consecutive inputs give 128 consecutive valid outputs. Writing a new block does not corrupt the block being read.
- R6: A cycle with `in_valid` low neither writes data nor advances the write position, and the data on `in_data` in that cycle is ignored. The copy waits until 64 writes have completed, so 63 writes alone give no output.
- R7: A write with `in_first` high stores its element at position 0, and counting restarts from there. Elements of an abandoned partial block are never emitted.
- R8: When no further block is written, `out_valid` returns to 0 after the 64th output and stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | An element is present on `in_data` |
| in_first | input | 1 | With `in_valid`, marks the element as the first of a block |
| in_data | input | DATA_W | Row-ordered input element |
| out_valid | output | 1 | `out_data` holds a transposed element |
| out_first | output | 1 | Marks the first output element of a block |
| out_data | output | DATA_W | Column-ordered output element |

## Verification
Two things can happen on the same edge: the copy of a newly completed block into the read bank, and the read of the last element of the block before it. The first element of the next block can also be written on that same edge. The bench provokes this collision by writing 128 elements with no gap between blocks. It then requires 128 valid outputs on consecutive cycles, with `out_first` only at positions 0 and 64 and with every element in the order that R3 gives, so a read that saw the new contents or a lost cycle would show up at once. A second run spreads the writes out with idle cycles carrying junk data, to check that the copy is held back until the 64th real write.

// File: rtl/xpose_pkg.sv
package xpose_pkg;
  // Default edge length of the square block
  localparam int unsigned DEF_DIM    = 8;
  // Default element width
  localparam int unsigned DEF_DATA_W = 12;
endpackage

// File: rtl/xpose_wr_ctrl.sv
module xpose_wr_ctrl #(
  parameter int unsigned DIM = xpose_pkg::DEF_DIM,
  localparam int unsigned NUM   = DIM * DIM,
  localparam int unsigned IDX_W = $clog2(NUM)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic             in_first,
  output logic             wr_en,
  output logic [IDX_W-1:0] wr_idx,
  output logic             copy_req
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM - 1);

  logic [IDX_W-1:0] wcnt_q;

  assign wr_en  = in_valid;
  assign wr_idx = in_first ? '0 : wcnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      wcnt_q   <= '0;
      copy_req <= 1'b0;
    end else begin
      copy_req <= in_valid && (wr_idx == LAST);
      if (in_valid) begin
        wcnt_q <= (wr_idx == LAST) ? '0 : wr_idx + 1'b1;
      end
    end
  end

  AST_STALL_HOLDS_POS: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(wcnt_q)); // R6
  AST_COPY_SINGLE: assert property (@(posedge clk) disable iff (rst)
    copy_req |=> !copy_req); // R5
endmodule

// File: rtl/xpose_reg_array.sv
module xpose_reg_array #(
  parameter int unsigned DIM    = xpose_pkg::DEF_DIM,
  parameter int unsigned DATA_W = xpose_pkg::DEF_DATA_W,
  localparam int unsigned NUM   = DIM * DIM,
  localparam int unsigned IDX_W = $clog2(NUM)
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              copy,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data
);
  logic [NUM*DATA_W-1:0] col_flat;

  for (genvar g = 0; g < NUM; g++) begin : g_cell
    logic [DATA_W-1:0] row_q;
    logic [DATA_W-1:0] col_q;

    always_ff @(posedge clk) begin
      if (wr_en && (wr_idx == IDX_W'(g))) begin
        row_q <= wr_data;
      end
      if (copy) begin
        col_q <= row_q;
      end
    end

    assign col_flat[g*DATA_W +: DATA_W] = col_q;
  end

  assign rd_data = col_flat[int'(rd_idx)*DATA_W +: DATA_W];
endmodule

// File: rtl/xpose_rd_ctrl.sv
module xpose_rd_ctrl #(
  parameter int unsigned DIM = xpose_pkg::DEF_DIM,
  localparam int unsigned NUM   = DIM * DIM,
  localparam int unsigned LOG_D = $clog2(DIM),
  localparam int unsigned IDX_W = 2 * LOG_D
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             copy,
  output logic             rd_fire,
  output logic [IDX_W-1:0] rd_idx,
  output logic             out_valid,
  output logic             out_first
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM - 1);

  logic             active_q;
  logic [IDX_W-1:0] rcnt_q;
  logic             seen_copy_q;

  assign rd_fire = active_q;
  // count = col*DIM + row -> storage index row*DIM + col
  assign rd_idx  = {rcnt_q[LOG_D-1:0], rcnt_q[IDX_W-1:LOG_D]};

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q    <= 1'b0;
      rcnt_q      <= '0;
      out_valid   <= 1'b0;
      out_first   <= 1'b0;
      seen_copy_q <= 1'b0;
    end else begin
      out_valid <= active_q;
      out_first <= active_q && (rcnt_q == '0);
      if (copy) begin
        seen_copy_q <= 1'b1;
        active_q    <= 1'b1;
        rcnt_q      <= '0;
      end else if (active_q) begin
        rcnt_q <= rcnt_q + 1'b1;
        if (rcnt_q == LAST) begin
          active_q <= 1'b0;
        end
      end
    end
  end

  AST_FIRST_HAS_VALID: assert property (@(posedge clk) disable iff (rst)
    out_first |-> out_valid); // R4
  AST_COPY_TO_FIRST: assert property (@(posedge clk) disable iff (rst)
    copy |=> ##1 out_first); // R2
  AST_NO_EARLY_VALID: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> seen_copy_q); // R1
endmodule

// File: rtl/xpose_dbl_buf.sv
module xpose_dbl_buf #(
  parameter int unsigned DIM    = xpose_pkg::DEF_DIM,
  parameter int unsigned DATA_W = xpose_pkg::DEF_DATA_W,
  localparam int unsigned NUM   = DIM * DIM,
  localparam int unsigned IDX_W = $clog2(NUM)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic              in_first,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  output logic              out_first,
  output logic [DATA_W-1:0] out_data
);
  logic             wr_en;
  logic [IDX_W-1:0] wr_idx;
  logic             copy;
  logic             rd_fire;
  logic [IDX_W-1:0] rd_idx;
  logic [DATA_W-1:0] rd_data;

  xpose_wr_ctrl #(.DIM(DIM)) u_wr (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_first(in_first),
    .wr_en(wr_en), .wr_idx(wr_idx), .copy_req(copy)
  );

  xpose_reg_array #(.DIM(DIM), .DATA_W(DATA_W)) u_arr (
    .clk(clk), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(in_data),
    .copy(copy), .rd_idx(rd_idx), .rd_data(rd_data)
  );

  xpose_rd_ctrl #(.DIM(DIM)) u_rd (
    .clk(clk), .rst(rst), .copy(copy), .rd_fire(rd_fire), .rd_idx(rd_idx),
    .out_valid(out_valid), .out_first(out_first)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_data <= '0;
    end else if (rd_fire) begin
      out_data <= rd_data;
    end
  end

  AST_RUN_CONTIGUOUS: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_first) |-> $past(out_valid)); // R4
endmodule

// File: tb/tb_xpose_dbl_buf.sv
module tb_xpose_dbl_buf;
  localparam int DW  = 12;
  localparam int CAP = 512;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic in_first = 1'b0;
  logic [DW-1:0] in_data = '0;
  logic out_valid, out_first;
  logic [DW-1:0] out_data;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int cap_n = 0;
  int cap_data [CAP];
  bit cap_first [CAP];
  int cap_cyc [CAP];
  int last_wr = 0;
  bit done = 1'b0;

  xpose_dbl_buf #(.DIM(8), .DATA_W(DW)) dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_first(in_first),
    .in_data(in_data), .out_valid(out_valid), .out_first(out_first),
    .out_data(out_data)
  );

  always #2 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (!rst && out_valid && cap_n < CAP) begin
      cap_data[cap_n]  = int'(out_data);
      cap_first[cap_n] = out_first;
      cap_cyc[cap_n]   = cyc;
      cap_n = cap_n + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic send(input int value, input bit first);
    @(negedge clk);
    in_valid = 1'b1;
    in_first = first;
    in_data  = DW'(value);
    last_wr  = cyc + 1;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      in_first = 1'b0;
      in_data  = '1;
    end
  endtask

  function automatic int expect_val(input int tag, input int k);
    return tag * 64 + (k % 8) * 8 + (k / 8);
  endfunction

  // compare one captured block starting at capture index base
  task automatic check_block(input int base, input int tag, input int w0, input string req);
    int bad_data = 0, bad_first = 0, bad_gap = 0;
    int first_bad_act = 0, first_bad_exp = 0;
    for (int k = 0; k < 64; k++) begin
      if (cap_data[base+k] != expect_val(tag, k)) begin
        if (bad_data == 0) begin
          first_bad_act = cap_data[base+k];
          first_bad_exp = expect_val(tag, k);
        end
        bad_data++;
      end
      if (cap_first[base+k] != (k == 0)) bad_first++;
      if (k > 0 && cap_cyc[base+k] != cap_cyc[base+k-1] + 1) bad_gap++;
    end
    chk(bad_data == 0, {req, "/R3 column order"}, first_bad_act, first_bad_exp);
    chk(bad_first == 0, {req, "/R4 first marker"}, bad_first, 0);
    chk(bad_gap == 0, {req, "/R4 consecutive outputs"}, bad_gap, 0);
    chk(cap_cyc[base] == w0 + 65, {req, "/R2 latency"}, cap_cyc[base], w0 + 65);
  endtask

  task automatic t_reset;
    chk(out_valid == 1'b0, "R1 out_valid after reset", int'(out_valid), 0);
    chk(out_first == 1'b0, "R1 out_first after reset", int'(out_first), 0);
  endtask

  task automatic t_single;
    int w0;
    cap_n = 0;
    for (int i = 0; i < 64; i++) begin
      send(1 * 64 + i, i == 0);
      if (i == 0) w0 = last_wr;
      if (i == 62) chk(cap_n == 0, "R1 no output before full block", cap_n, 0);
    end
    idle(150);
    chk(cap_n == 64, "R8 single block count then idle", cap_n, 64);
    check_block(0, 1, w0, "R2 single");
  endtask

  task automatic t_back_to_back;
    int w0, w1;
    cap_n = 0;
    for (int i = 0; i < 128; i++) begin
      send((i < 64 ? 3 : 4) * 64 + (i % 64), 1'b0);
      if (i == 0) w0 = last_wr;
      if (i == 64) w1 = last_wr;
    end
    idle(150);
    chk(cap_n == 128, "R5 back-to-back count", cap_n, 128);
    check_block(0, 3, w0, "R5 block A");
    check_block(64, 4, w1, "R5 block B");
    chk(cap_cyc[64] == cap_cyc[63] + 1, "R5 no gap between blocks",
        cap_cyc[64] - cap_cyc[63], 1);
  endtask

  task automatic t_stall;
    int exp_first;
    cap_n = 0;
    for (int i = 0; i < 63; i++) begin
      send(5 * 64 + i, i == 0);
      if (i % 3 == 2) idle(1);
    end
    idle(120);
    chk(cap_n == 0, "R6 63 writes give no output", cap_n, 0);
    send(5 * 64 + 63, 1'b0);
    exp_first = last_wr + 2;
    idle(150);
    chk(cap_n == 64, "R6 stalled block count", cap_n, 64);
    chk(cap_cyc[0] == exp_first, "R6 copy after 64th write", cap_cyc[0], exp_first);
    // latency is not measured from the first write here; only the data checks apply
    begin
      int bad = 0;
      for (int k = 0; k < 64; k++)
        if (cap_data[k] != expect_val(5, k) || cap_first[k] != (k == 0)) bad++;
      chk(bad == 0, "R6 junk on idle cycles ignored, R3 order kept", bad, 0);
    end
  endtask

  task automatic t_restart;
    int w0;
    cap_n = 0;
    for (int i = 0; i < 20; i++) send(9 * 64 + i, i == 0);
    for (int i = 0; i < 64; i++) begin
      send(10 * 64 + i, i == 0);
      if (i == 0) w0 = last_wr;
    end
    idle(150);
    chk(cap_n == 64, "R7 restart yields one block", cap_n, 64);
    check_block(0, 10, w0, "R7 restart");
  endtask

  always @(posedge clk) begin
    if (!done && cyc > 100000) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 100000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    in_data = '1;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_single();
    t_back_to_back();
    t_stall();
    t_restart();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule